// File: doc/BRIEF.md
# Complementary Pair Dead-Band Inserter

This block takes the single PWM waveform that drives a channel pair and turns it into two complementary pin drives: a high-side leg that is active while the waveform is high, and a low-side leg that is active while it is low. When insertion is switched on, every transition of the waveform opens a dead band. During the band neither leg is active, and its length is a programmable number of count-clock cycles. This keeps the two switches of a half bridge from conducting at the same time.

The pair reads a single configuration word. Bits [15:8] hold the 8-bit band length and bit 0 switches insertion on. The bits in between are ignored. With insertion off, the legs are a direct, zero-latency copy of the waveform and of its complement. A waveform pulse that is no longer than the band leaves its leg inactive for the whole pulse. The band length is captured at the transition that opens the band.

Top module: `deadband_pair`

## Requirements
- R1: After reset the transition detector holds a low previous level and no band is pending. With insertion on and the waveform low, the low-side leg is active and the high-side leg is inactive in the first cycle after reset.
- R2: The band length D is read from config bits [15:8] and the insertion switch from bit 0. Bits [7:1] have no effect on either leg.
- R3: With bit 0 clear, the high-side leg equals the waveform and the low-side leg equals its complement in the same cycle, whatever D is.
- R4: With insertion on and D>0, a rising transition makes both legs inactive for exactly D cycles, counting the cycle in which the waveform changes. After that the high-side leg is active while the waveform stays high.
- R5: With insertion on and D>0, a falling transition makes both legs inactive for exactly D cycles. After that the low-side leg is active while the waveform stays low.
- R6: The two legs are never active in the same cycle.
- R7: With insertion on, a waveform level that lasts D cycles or fewer leaves its leg inactive for that whole level.
- R8: With insertion on and D=0, the legs behave as in R3, with no band.
- R9: D is captured at the transition. A change of bits [15:8] during a band does not change that band's length.
- R10: Clearing bit 0 cancels any pending band. Setting bit 0 while the waveform is steady opens no band until the next transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Raw PWM waveform of the pair |
| dz_cfg_i | input | 16 | Pair config word: [15:8] band length, [0] insertion on |
| out_hi_o | output | 1 | High-side leg, active high |
| out_lo_o | output | 1 | Low-side leg, active high |

## Verification
The block holds only two pieces of state: the previous waveform level and the band counter. A wrong previous level shows at the legs in the same cycle as a missing band or a spurious one. A counter that is off by one moves the end of a band by a cycle, which a per-cycle comparison catches at the band's last cycle. A counter that fails to clear or reload shows either as a leg that never becomes active or as both legs dropping out with no transition. Directed runs pin down band lengths of 0, 1, 3 and 255, pulses around D, and changes to the band length and the switch in the middle of a band. A long seeded random run then compares every cycle against an independent model.

// File: rtl/deadband_pkg.sv
package deadband_pkg;
  // Config word layout of one channel pair
  localparam int unsigned CFG_W   = 16;
  localparam int unsigned IVL_LSB = 8;
  localparam int unsigned IVL_W   = 8;
  localparam int unsigned EN_POS  = 0;

  // Leg identifiers for the output stage
  typedef enum logic [0:0] {
    LEG_HI = 1'b0,
    LEG_LO = 1'b1
  } leg_e;

  function automatic logic [IVL_W-1:0] cfg_ivl(input logic [CFG_W-1:0] cfg);
    return cfg[IVL_LSB +: IVL_W];
  endfunction

  function automatic logic cfg_en(input logic [CFG_W-1:0] cfg);
    return cfg[EN_POS];
  endfunction
endpackage

// File: rtl/deadband_edge_det.sv
module deadband_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic edge_o
);
  logic prev_q;
  logic prev_d;
  logic prev_ce;

  always_comb begin
    prev_ce = (sig_i != prev_q);
    prev_d  = sig_i;
    edge_o  = prev_ce;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (prev_ce) begin
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/deadband_band_cnt.sv
module deadband_band_cnt #(
  parameter int unsigned IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             edge_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic [IVL_W-1:0] cnt_q_o,
  output logic             band_o
);
  localparam logic [IVL_W-1:0] CNT_ZERO = '0;
  localparam logic [IVL_W-1:0] CNT_ONE  = {{(IVL_W-1){1'b0}}, 1'b1};

  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] cnt_d;
  logic             cnt_ce;
  logic             busy;

  always_comb begin
    busy   = (cnt_q != CNT_ZERO);
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (!en_i) begin
      cnt_d  = CNT_ZERO;
      cnt_ce = busy;
    end else if (edge_i) begin
      cnt_d  = ivl_i;
      cnt_ce = 1'b1;
    end else if (busy) begin
      cnt_d  = cnt_q - CNT_ONE;
      cnt_ce = 1'b1;
    end
    band_o = en_i && (cnt_d != CNT_ZERO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_q_o = cnt_q;
endmodule

// File: rtl/deadband_out_stage.sv
module deadband_out_stage
  import deadband_pkg::*;
#(
  parameter int unsigned N_LEGS = 2
) (
  input  logic              en_i,
  input  logic              sig_i,
  input  logic              band_i,
  output logic [N_LEGS-1:0] leg_o
);
  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    localparam leg_e KIND = (g == 0) ? LEG_HI : LEG_LO;
    logic level;
    always_comb begin
      level = (KIND == LEG_LO) ? ~sig_i : sig_i;
      if (en_i) begin
        leg_o[g] = level & ~band_i;
      end else begin
        leg_o[g] = level;
      end
    end
  end
endmodule

// File: rtl/deadband_pair.sv
module deadband_pair
  import deadband_pkg::*;
#(
  parameter int unsigned CW = CFG_W,
  parameter int unsigned DW = IVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_i,
  input  logic [CW-1:0] dz_cfg_i,
  output logic          out_hi_o,
  output logic          out_lo_o
);
  localparam int unsigned N_LEGS = 2;

  logic              ins_en;
  logic [DW-1:0]     ivl;
  logic              edge_seen;
  logic              band;
  logic [DW-1:0]     cnt_q;
  logic [N_LEGS-1:0] legs;

  always_comb begin
    ins_en = dz_cfg_i[EN_POS];
    ivl    = dz_cfg_i[IVL_LSB +: DW];
  end

  deadband_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (pwm_i),
    .edge_o (edge_seen)
  );

  deadband_band_cnt #(.IVL_W(DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (ins_en),
    .edge_i  (edge_seen),
    .ivl_i   (ivl),
    .cnt_q_o (cnt_q),
    .band_o  (band)
  );

  deadband_out_stage #(.N_LEGS(N_LEGS)) u_out (
    .en_i   (ins_en),
    .sig_i  (pwm_i),
    .band_i (band),
    .leg_o  (legs)
  );

  assign out_hi_o = legs[0];
  assign out_lo_o = legs[1];
endmodule

// File: rtl/deadband_pair_chk.sv
module deadband_pair_chk #(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwm_i,
  input logic [CW-1:0] dz_cfg_i,
  input logic          out_hi_o,
  input logic          out_lo_o,
  input logic [DW-1:0] cnt_q
);
  logic          en_c;
  logic [DW-1:0] ivl_c;
  assign en_c  = dz_cfg_i[0];
  assign ivl_c = dz_cfg_i[8 +: DW];

  // R6: legs mutually exclusive
  assert_never_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hi_o && out_lo_o));

  // R3: bypass copies the waveform
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_c |-> (out_hi_o == pwm_i) && (out_lo_o == !pwm_i));

  // R4: high leg only active while waveform high
  assert_hi_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && out_hi_o) |-> pwm_i);

  // R5: low leg only active while waveform low
  assert_lo_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && out_lo_o) |-> !pwm_i);

  // R4: a pending band of more than one cycle keeps both legs off
  assert_band_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && ivl_c != '0 && cnt_q > 1) |-> (!out_hi_o && !out_lo_o));

  // R10: switching off cancels the pending band
  assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_c |=> (cnt_q == '0) || $past(en_c) == 1'b0 && en_c);
endmodule

bind deadband_pair deadband_pair_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_i    (pwm_i),
  .dz_cfg_i (dz_cfg_i),
  .out_hi_o (out_hi_o),
  .out_lo_o (out_lo_o),
  .cnt_q    (cnt_q)
);

// File: tb/deadband_pair_tb.sv
module deadband_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwm;
  logic [15:0] cfg;
  logic        hi, lo;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model state
  logic m_prev;
  int   m_cnt;

  always #10 clk = ~clk;

  deadband_pair u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .dz_cfg_i(cfg),
    .out_hi_o(hi), .out_lo_o(lo)
  );

  function automatic int ref_next(input logic p, input logic en, input int d,
                                  input logic prev, input int cnt);
    if (!en) return 0;
    if (p != prev) return d;
    return (cnt > 0) ? cnt - 1 : 0;
  endfunction

  task automatic check(input string req, input logic eh, input logic el);
    n_tests++;
    if (hi !== eh || lo !== el) begin
      n_fail++;
      $display("FAIL %s hi=%b lo=%b expected hi=%b lo=%b", req, hi, lo, eh, el);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle, compare with the model, advance the model
  task automatic step(input logic p, input logic en, input int d,
                      input logic [6:0] junk, input string req);
    int  nc;
    logic band, eh, el;
    @(negedge clk);
    pwm = p;
    cfg = {d[7:0], junk, en};
    #5;
    nc   = ref_next(p, en, d, m_prev, m_cnt);
    band = en && (nc != 0);
    eh   = en ? (p && !band) : p;
    el   = en ? (!p && !band) : !p;
    check(req, eh, el);
    m_prev = p;
    m_cnt  = nc;
  endtask

  // hold a level and return the number of cycles with both legs off
  task automatic hold(input logic p, input logic en, input int d, input int n,
                      input string req, output int quiet);
    quiet = 0;
    for (int i = 0; i < n; i++) begin
      step(p, en, d, 7'h00, req);
      if (!hi && !lo) quiet++;
    end
  endtask

  initial begin
    int q;
    int unsigned seed;
    rst_n = 1'b0;
    pwm   = 1'b0;
    cfg   = 16'h0401;
    m_prev = 1'b0;
    m_cnt  = 0;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    step(1'b0, 1'b1, 4, 7'h00, "R1");
    check("R1", 1'b0, 1'b1);

    // R3: bypass with a large band programmed
    hold(1'b1, 1'b0, 200, 3, "R3", q);
    check_int("R3 quiet cycles", q, 0);
    hold(1'b0, 1'b0, 200, 3, "R3", q);
    check_int("R3 quiet cycles", q, 0);

    // R8: zero band
    hold(1'b1, 1'b1, 0, 4, "R8", q);
    check_int("R8 quiet cycles", q, 0);
    hold(1'b0, 1'b1, 0, 4, "R8", q);
    check_int("R8 quiet cycles", q, 0);

    // R4 / R5: band of 3
    hold(1'b1, 1'b1, 3, 8, "R4", q);
    check_int("R4 band length", q, 3);
    check("R4", 1'b1, 1'b0);
    hold(1'b0, 1'b1, 3, 8, "R5", q);
    check_int("R5 band length", q, 3);
    check("R5", 1'b0, 1'b1);

    // R4: band of 1
    hold(1'b1, 1'b1, 1, 4, "R4", q);
    check_int("R4 band of one", q, 1);

    // R7: pulse equal to band and shorter than band
    hold(1'b0, 1'b1, 4, 6, "R7", q);
    hold(1'b1, 1'b1, 4, 4, "R7", q);
    check_int("R7 pulse equal band", q, 4);
    hold(1'b0, 1'b1, 4, 2, "R7", q);
    check_int("R7 short low pulse", q, 2);
    hold(1'b1, 1'b1, 4, 5, "R7", q);
    check_int("R7 pulse one longer", q, 4);

    // R2: junk bits do not matter
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 2, 7'h7F, "R2");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 2, 7'h55, "R2");

    // R9: band length changed mid band
    step(1'b1, 1'b1, 5, 7'h00, "R9");
    q = 1;
    for (int i = 0; i < 7; i++) begin
      step(1'b1, 1'b1, 1, 7'h00, "R9");
      if (!hi && !lo) q++;
    end
    check_int("R9 captured length", q, 5);

    // R10: disable mid band cancels it, enable mid level opens none
    step(1'b0, 1'b1, 6, 7'h00, "R10");
    step(1'b0, 1'b1, 6, 7'h00, "R10");
    step(1'b0, 1'b0, 6, 7'h00, "R10");
    step(1'b0, 1'b1, 6, 7'h00, "R10");
    check("R10", 1'b0, 1'b1);

    // R4: longest band
    hold(1'b1, 1'b1, 255, 260, "R4", q);
    check_int("R4 band of 255", q, 255);

    // random phase
    for (int s = 0; s < 600; s++) begin
      logic p, en;
      int d, len;
      logic [6:0] j;
      p   = $urandom() % 2;
      en  = ($urandom() % 8) != 0;
      d   = ($urandom() % 10 == 0) ? ($urandom() % 256) : ($urandom() % 7);
      len = 1 + $urandom() % 10;
      j   = 7'($urandom());
      for (int c = 0; c < len; c++) begin
        step(p, en, d, j, "R6");
        if (hi && lo) check_int("R6 both legs", 1, 0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule